// File: doc/BRIEF.md
# Debug Trigger Pair Combiner

This block turns raw per-trigger match flags from a processor's debug logic into final fire decisions. It serves ten triggers arranged in five fixed pairs: pair p holds triggers 2p and 2p+1. Pair 0 holds two fetch triggers. Pair 1 holds two store triggers. Pair 2 holds two load triggers. Pair 3 holds a fetch trigger (even) and a store trigger (odd). Pair 4 holds a fetch trigger (even) and a load trigger (odd). So triggers 4, 5 and 9 are load triggers, and triggers 2, 3 and 7 are store triggers.

Each trigger holds three configuration bits: an enable bit, a timing bit and a data-compare bit. Each pair also holds one link bit. All of these are loaded through a single-cycle write port. The write carries a trigger index and the new values. The link bit of pair p is written only through the record of its even trigger 2p.

Matching of addresses and data, privilege filtering and trap entry all happen elsewhere. This block only combines the flags, applies the pair links and rejects illegal setups. The outputs are combinational in the match inputs and use the registered configuration.

Top module: `trig_pair_combiner`

## Requirements
- R1: After a synchronous reset, every enable, timing, data-compare and link bit is 0, so `fire` stays all zero for any `hit` pattern until triggers are configured.
- R2: With the link bit of its pair clear, trigger t fires (`fire[t]`=1) exactly when `hit[t]` and its enable bit are both 1, independent of its partner.
- R3: With the link bit of pair p set, triggers 2p and 2p+1 fire together, and only when both are enabled and both hit in the same cycle; otherwise neither fires.
- R4: In a linked pair whose two members have different timing bits, neither member fires, even if both hit.
- R5: `fire_now` is 1 when any firing trigger has timing bit 0. `fire_next` is 1 when any firing trigger has timing bit 1. Timing 0 means a trap on the current instruction, and timing 1 means a trap on the next instruction.
- R6: A load trigger (index 4, 5 or 9) whose data-compare bit is 1 never fires. A linked pair containing such a trigger fires neither member.
- R7: When the link bit of pair 1 (the store+store pair, triggers 2 and 3) is set, neither trigger 2 nor trigger 3 fires.
- R8: A write with `cfg_valid`=1 takes effect from the next cycle. A match in the same cycle as the write is judged with the old configuration.
- R9: A write whose `cfg_idx` is 10 to 15 changes nothing.
- R10: A write to an odd trigger index leaves its pair's link bit unchanged. A write to an even index 2p loads `cfg_link` into the link bit of pair p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Trigger index of the write (0 to 9 valid) |
| cfg_en | input | 1 | New enable bit |
| cfg_timing | input | 1 | New timing bit (0 = current, 1 = next instruction) |
| cfg_dcmp | input | 1 | New data-compare bit |
| cfg_link | input | 1 | New pair link bit (used on even index only) |
| hit | input | 10 | Raw match flag per trigger |
| fire | output | 10 | Final fire flag per trigger |
| fire_now | output | 1 | Some firing trigger asks for a trap now |
| fire_next | output | 1 | Some firing trigger asks for a trap on the next instruction |

## Verification
The stimulus uses several kinds of patterns:
- Single-trigger hits with links clear. These separate the independent path from the linked path.
- Both-member and one-member hits on linked pairs. These show the AND behaviour.
- Linked pairs with equal and unequal timing. These expose the timing-mismatch suppression.
- Load triggers with data compare on, and the linked store pair. These show the two illegal setups staying silent.
- Writes coinciding with hits, writes to out-of-range indices and writes to odd indices. These separate old from new configuration and show which writes are dropped.
- A long randomized mix of writes and hits. This is compared against a behavioural model every cycle.

// File: rtl/trig_pair_combiner.sv
module trig_pair_combiner #(
  parameter int NPAIR = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic [3:0]       cfg_idx,
  input  logic             cfg_en,
  input  logic             cfg_timing,
  input  logic             cfg_dcmp,
  input  logic             cfg_link,
  input  logic [9:0]       hit,
  output logic [9:0]       fire,
  output logic             fire_now,
  output logic             fire_next
);
  localparam int NTRIG = 2 * NPAIR;
  localparam logic [NTRIG-1:0] LOAD_MASK = 10'b10_0011_0000;
  localparam int STORE_PAIR = 1;

  logic [NTRIG-1:0] en_q, tim_q, dcmp_q;
  logic [NPAIR-1:0] link_q;
  logic [NTRIG-1:0] ok;

  wire wr = cfg_valid && (cfg_idx < 4'(NTRIG));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      tim_q  <= '0;
      dcmp_q <= '0;
      link_q <= '0;
    end else if (wr) begin
      en_q[cfg_idx]   <= cfg_en;
      tim_q[cfg_idx]  <= cfg_timing;
      dcmp_q[cfg_idx] <= cfg_dcmp;
      if (!cfg_idx[0]) link_q[cfg_idx[3:1]] <= cfg_link;
    end
  end

  assign ok = hit & en_q & ~(LOAD_MASK & dcmp_q);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic both;
    if (p == STORE_PAIR) begin : g_st
      assign both = 1'b0;
    end else begin : g_norm
      assign both = ok[2*p] & ok[2*p+1] & (tim_q[2*p] == tim_q[2*p+1]);
    end
    assign fire[2*p+1:2*p] = link_q[p] ? {both, both} : ok[2*p+1:2*p];
  end

  assign fire_now  = |(fire & ~tim_q);
  assign fire_next = |(fire & tim_q);
endmodule

module trig_pair_combiner_chk (
  input logic       clk,
  input logic       rst,
  input logic [9:0] hit,
  input logic [9:0] fire,
  input logic       fire_now,
  input logic       fire_next,
  input logic [9:0] tim_q,
  input logic [4:0] link_q
);
  AST_FIRE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst) (fire & ~hit) == 10'b0); // R2
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> fire == 10'b0); // R1
  AST_ANY_SPLIT: assert property (@(posedge clk) disable iff (rst) (|fire) == (fire_now | fire_next)); // R5
  AST_STORE_LINK_SILENT: assert property (@(posedge clk) disable iff (rst) link_q[1] |-> fire[3:2] == 2'b00); // R7
  for (genvar p = 0; p < 5; p++) begin : g_a
    AST_LINK_TOGETHER: assert property (@(posedge clk) disable iff (rst) link_q[p] |-> fire[2*p] == fire[2*p+1]); // R3
    AST_LINK_TIMING: assert property (@(posedge clk) disable iff (rst)
      (link_q[p] && tim_q[2*p] != tim_q[2*p+1]) |-> fire[2*p+1:2*p] == 2'b00); // R4
  end
endmodule

bind trig_pair_combiner trig_pair_combiner_chk u_chk (
  .clk(clk), .rst(rst), .hit(hit), .fire(fire), .fire_now(fire_now),
  .fire_next(fire_next), .tim_q(tim_q), .link_q(link_q)
);

// File: tb/test_trig_pair_combiner.sv
module test_trig_pair_combiner;
  localparam time TCLK = 10ns;

  logic clk = 0, rst = 1;
  logic cfg_valid = 0, cfg_en = 0, cfg_timing = 0, cfg_dcmp = 0, cfg_link = 0;
  logic [3:0] cfg_idx = 0;
  logic [9:0] hit = 0;
  logic [9:0] fire;
  logic fire_now, fire_next;

  int total = 0, bad = 0;
  string tag = "R1";

  bit m_en[10], m_tim[10], m_dcmp[10], m_link[5];
  int kind[10];

  trig_pair_combiner i_trig_pair_combiner (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_timing(cfg_timing), .cfg_dcmp(cfg_dcmp), .cfg_link(cfg_link), .hit(hit),
    .fire(fire), .fire_now(fire_now), .fire_next(fire_next)
  );

  always #(TCLK/2) clk = ~clk;

  function automatic logic [11:0] expect_out();
    logic [9:0] f = '0;
    bit ok[10];
    bit nw = 0, nx = 0;
    for (int t = 0; t < 10; t++)
      ok[t] = hit[t] && m_en[t] && !(kind[t] == 2 && m_dcmp[t]);
    for (int p = 0; p < 5; p++) begin
      if (m_link[p]) begin
        if (p != 1 && ok[2*p] && ok[2*p+1] && m_tim[2*p] == m_tim[2*p+1]) begin
          f[2*p] = 1; f[2*p+1] = 1;
        end
      end else begin
        f[2*p] = ok[2*p]; f[2*p+1] = ok[2*p+1];
      end
    end
    for (int t = 0; t < 10; t++) if (f[t]) begin
      if (m_tim[t]) nx = 1; else nw = 1;
    end
    return {nw, nx, f};
  endfunction

  task automatic check();
    logic [11:0] e;
    #1;
    e = expect_out();
    total++;
    if ({fire_now, fire_next, fire} !== e) begin
      bad++;
      $display("FAIL %s: got now=%b next=%b fire=%b, expected now=%b next=%b fire=%b",
               tag, fire_now, fire_next, fire, e[11], e[10], e[9:0]);
    end
  endtask

  task automatic cycle();
    check();
    @(posedge clk);
    if (rst) begin
      for (int t = 0; t < 10; t++) begin m_en[t] = 0; m_tim[t] = 0; m_dcmp[t] = 0; end
      for (int p = 0; p < 5; p++) m_link[p] = 0;
    end else if (cfg_valid && cfg_idx < 10) begin
      m_en[cfg_idx] = cfg_en; m_tim[cfg_idx] = cfg_timing; m_dcmp[cfg_idx] = cfg_dcmp;
      if (!cfg_idx[0]) m_link[cfg_idx >> 1] = cfg_link;
    end
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic wr(int idx, bit en, bit tm, bit dc, bit lk);
    cfg_valid = 1; cfg_idx = 4'(idx); cfg_en = en; cfg_timing = tm; cfg_dcmp = dc; cfg_link = lk;
    cycle();
  endtask

  task automatic hits(logic [9:0] h);
    hit = h; cycle(); hit = '0;
  endtask

  initial begin
    kind = '{0,0,1,1,2,2,0,1,0,2};
    fork
      begin
        #(TCLK * 100000);
        bad++; total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    @(negedge clk);
    cycle(); rst = 0;
    tag = "R1"; hits(10'h3FF); hits(10'h155);
    tag = "R2";
    for (int t = 0; t < 10; t++) wr(t, 1, t % 2, 0, 0);
    for (int t = 0; t < 10; t++) hits(10'(1 << t));
    hits(10'h3FF);
    tag = "R5"; hits(10'h001); hits(10'h002); hits(10'h003);
    tag = "R3";
    wr(0, 1, 0, 0, 1); wr(1, 1, 0, 0, 0);
    hits(10'h001); hits(10'h002); hits(10'h003);
    wr(1, 0, 0, 0, 0); hits(10'h003);
    tag = "R10"; wr(1, 1, 0, 0, 0); hits(10'h001); hits(10'h003);
    tag = "R4"; wr(8, 1, 1, 0, 1); wr(9, 1, 0, 0, 0); hits(10'h300);
    wr(9, 1, 1, 0, 0); hits(10'h300); hits(10'h100);
    tag = "R6"; wr(5, 1, 0, 1, 0); hits(10'h030); hits(10'h010);
    wr(9, 1, 1, 1, 0); hits(10'h300);
    tag = "R7"; wr(2, 1, 0, 0, 1); wr(3, 1, 0, 0, 0); hits(10'h00C); hits(10'h004);
    tag = "R8"; cfg_valid = 1; cfg_idx = 6; cfg_en = 0; cfg_timing = 0; cfg_dcmp = 0; cfg_link = 0;
    hit = 10'h040; cycle(); cycle(); hit = '0;
    tag = "R9"; wr(12, 1, 1, 0, 1); hits(10'h3FF); wr(15, 0, 0, 0, 0); hits(10'h3FF);
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      cfg_valid = $urandom_range(0, 2) == 0; cfg_idx = 4'($urandom_range(0, 15));
      cfg_en = $urandom_range(0, 3) != 0; cfg_timing = 1'($urandom); cfg_dcmp = $urandom_range(0, 3) == 0;
      cfg_link = 1'($urandom); hit = 10'($urandom);
      cycle();
    end
    tag = "R1"; rst = 1; hit = 10'h3FF; cycle(); rst = 0; cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule